// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the horizontal and vertical timing for an interlaced 625-line encoder. It runs on the pixel clock and counts pixels along each line and lines through each frame. From those counts it drives an active-low horizontal sync, a combined field/vertical-sync output, and a strobe that marks where active pixel data belongs on each line. A line lasts 864 pixel clocks by default, which is 64 µs at 13.5 MHz.

Software sets the timing through two 8-bit registers. Pulse widths and edge offsets are not linear counts: each is picked from a small coded set of pixel-clock values. The field/vertical output works in one of two ways. In the first it is a field level that changes at the field boundaries, with an optional half-line shift of the edge. In the second it is an active-low vertical pulse at the start of each field. A restart bit must be raised and then dropped to realign the counters. The values written to the registers take effect only at that realignment, so a pulse is never cut short in the middle of a frame.

Top module: `vid_sync_gen`

## Requirements
- R1: While the active configuration is slave (register 0 bit 0 = 0), and during reset, the block holds `hsync_no` = 1, `field_vsync_o` = 1 and `pix_valid_o` = 0. Reset loads a slave configuration.
- R2: Each line lasts `LINE_PIX` clocks, so `hsync_no` falls once every `LINE_PIX` clocks. A frame holds `LINES` lines, counted from 1.
- R3: `hsync_no` stays low for 1, 4, 16 or 128 clocks when register 1 bits [1:0] are 0, 1, 2 or 3.
- R4: `pix_valid_o` rises `HBLANK` + a clocks after the falling edge of `hsync_no`, where a = register 1 bits [7:6] (0 to 3). It stays high until the next falling edge of `hsync_no`.
- R5: In field mode (register 0 bit 1 = 0), `field_vsync_o` is low for lines 1 to `FIELD1_LINES` and high for the rest of the frame. Successive field edges are therefore `FIELD1_LINES` and `LINES - FIELD1_LINES` lines apart, alternately.
- R6: The field edge, or the start of the vertical pulse, comes 0, 4, 8 or 16 clocks after the falling edge of `hsync_no` on its line, for register 1 bits [3:2] = 0, 1, 2 or 3.
- R7: In field mode, register 0 bit 2 = 1 adds `LINE_PIX/2` clocks (half a line) to the field edge offset.
- R8: In vertical-pulse mode (register 0 bit 1 = 1), `field_vsync_o` goes low at the R6 offset on line 1 and on line `FIELD1_LINES+1`. It stays low for 1, 4, 16 or 128 clocks, for register 1 bits [5:4] = 0, 1, 2 or 3.
- R9: The counters restart only when register 0 bit 3 is written 1 and later written 0. While the bit stays 1 the counters keep running. After the write edge that clears the bit, outputs are inactive for one cycle and `hsync_no` falls on the next cycle. Writing 0 when the bit is already 0 does nothing.
- R10: Register writes reach the outputs only at an R9 restart. Until then the previous configuration stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 control, 1 timing |
| cfg_wdata_i | input | 8 | Register write data |
| hsync_no | output | 1 | Horizontal sync, active low |
| field_vsync_o | output | 1 | Field level or active-low vertical pulse |
| pix_valid_o | output | 1 | Active pixel data window |

## Verification
The bench measures every code of each coded width and offset against the falling edge of horizontal sync. A mapping that is off by one position, or a linear set in place of the coded one, would give the wrong clock count. It counts lines between field edges in both directions, and between vertical pulses, so a design that splits the frame at the wrong line, or that leaves out the pulse of the second field, is caught. It times the half-line shift. It holds the restart bit high to show that counting continues, and it writes the bit low a second time to show that nothing restarts. A design that restarts on any write or on the rising edge would then shift the sync phase. Register changes made without a restart must leave the width and the master state unchanged until the restart.

// File: rtl/vsg_pkg.sv
`timescale 1ns/1ps
package vsg_pkg;

  typedef struct packed {
    logic [1:0] adj;   // pixel data start shift
    logic [1:0] vs_w;  // vertical pulse width code
    logic [1:0] dly;   // sync-to-field delay code
    logic [1:0] hs_w;  // horizontal pulse width code
  } tim_t;

  typedef struct packed {
    logic master;
    logic vs_mode;
    logic half;
    tim_t tim;
  } cfg_t;

  function automatic logic [7:0] pulse_len(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd16;
      default: return 8'd128;
    endcase
  endfunction

  function automatic logic [4:0] edge_dly(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/vsg_cfg_regs.sv
`timescale 1ns/1ps
module vsg_cfg_regs
  import vsg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output cfg_t       act_o,
  output logic       restart_o
);

  logic [3:0] ctl_q;
  tim_t       tim_q;
  logic       rs_d1_q;
  cfg_t       act_q;

  // restart fires on the high-to-low transition of the stored bit
  assign restart_o = rs_d1_q & ~ctl_q[3];
  assign act_o     = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      tim_q   <= '0;
      rs_d1_q <= 1'b0;
      act_q   <= '0;
    end else begin
      if (we_i) begin
        if (addr_i) tim_q <= tim_t'(wdata_i);
        else        ctl_q <= wdata_i[3:0];
      end
      rs_d1_q <= ctl_q[3];
      if (restart_o) begin
        act_q.master  <= ctl_q[0];
        act_q.vs_mode <= ctl_q[1];
        act_q.half    <= ctl_q[2];
        act_q.tim     <= tim_q;
      end
    end
  end

  p_shadow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_o |=> $stable(act_q));

  p_restart_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

endmodule

// File: rtl/vsg_counters.sv
`timescale 1ns/1ps
module vsg_counters #(
  parameter int LINE_PIX = 864,
  parameter int LINES    = 625,
  localparam int PIX_W   = $clog2(LINE_PIX),
  localparam int LINE_W  = $clog2(LINES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o
);

  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(LINE_PIX - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] LINE_ONE  = LINE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o  <= '0;
      line_o <= LINE_ONE;
    end else if (clr_i) begin
      pix_o  <= '0;
      line_o <= LINE_ONE;
    end else if (pix_o == PIX_LAST) begin
      pix_o  <= '0;
      line_o <= (line_o == LINE_LAST) ? LINE_ONE : line_o + LINE_ONE;
    end else begin
      pix_o <= pix_o + PIX_W'(1);
    end
  end

  p_pix_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o <= PIX_LAST && line_o >= LINE_ONE && line_o <= LINE_LAST);

  p_frame_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o == PIX_LAST && line_o == LINE_LAST && !clr_i) |=> (pix_o == '0 && line_o == LINE_ONE));

  p_clr_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pix_o == '0 && line_o == LINE_ONE));

endmodule

// File: rtl/vsg_outputs.sv
`timescale 1ns/1ps
module vsg_outputs
  import vsg_pkg::*;
#(
  parameter int LINE_PIX     = 864,
  parameter int LINES        = 625,
  parameter int FIELD1_LINES = 313,
  parameter int HBLANK       = 144,
  localparam int PIX_W       = $clog2(LINE_PIX),
  localparam int LINE_W      = $clog2(LINES + 1),
  localparam int HALF        = LINE_PIX / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  cfg_t              cfg_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              hsync_no,
  output logic              field_vsync_o,
  output logic              pix_valid_o
);

  logic [15:0] pix16, hw16, fpos16, vpos16, de_thr16;
  logic [7:0]  vw;
  logic        line_f1, line_f2, vs_start;
  logic        hs_n_q, de_q, field_q, vs_n_q;
  logic [6:0]  vs_left_q;

  always_comb begin
    pix16    = 16'(pix_i);
    hw16     = 16'(pulse_len(cfg_i.tim.hs_w));
    vw       = pulse_len(cfg_i.tim.vs_w);
    vpos16   = 16'(edge_dly(cfg_i.tim.dly));
    fpos16   = vpos16 + (cfg_i.half ? 16'(HALF) : 16'd0);
    de_thr16 = 16'(HBLANK) + 16'(cfg_i.tim.adj);
    line_f1  = (line_i == LINE_W'(1));
    line_f2  = (line_i == LINE_W'(FIELD1_LINES + 1));
    vs_start = cfg_i.master && cfg_i.vs_mode && (line_f1 || line_f2) && (pix16 == vpos16);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_n_q    <= 1'b1;
      de_q      <= 1'b0;
      field_q   <= 1'b0;
      vs_n_q    <= 1'b1;
      vs_left_q <= '0;
    end else if (clr_i) begin
      hs_n_q    <= 1'b1;
      de_q      <= 1'b0;
      field_q   <= 1'b0;
      vs_n_q    <= 1'b1;
      vs_left_q <= '0;
    end else begin
      hs_n_q <= !(cfg_i.master && (pix16 < hw16));
      de_q   <= cfg_i.master && (pix16 >= de_thr16);
      if (pix16 == fpos16) begin
        if (line_f1)      field_q <= 1'b0;
        else if (line_f2) field_q <= 1'b1;
      end
      if (vs_start) begin
        vs_left_q <= 7'(vw - 8'd1);
        vs_n_q    <= 1'b0;
      end else if (vs_left_q != '0) begin
        vs_left_q <= vs_left_q - 7'd1;
        vs_n_q    <= 1'b0;
      end else begin
        vs_n_q <= 1'b1;
      end
    end
  end

  assign hsync_no      = hs_n_q;
  assign pix_valid_o   = de_q;
  assign field_vsync_o = !cfg_i.master ? 1'b1 : (cfg_i.vs_mode ? vs_n_q : field_q);

  p_slave_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.master |-> (hsync_no && field_vsync_o && !pix_valid_o));

  p_hs_line_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_n_q) |-> $past(pix_i) == '0);

  p_de_line_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(de_q) |-> ($past(pix_i) == '0 || $past(clr_i)));

  p_field_edge_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_q) |-> ($past(clr_i) || $past(pix16) == $past(fpos16)));

  p_vs_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_left_q != '0) |-> !vs_n_q);

endmodule

// File: rtl/vid_sync_gen.sv
`timescale 1ns/1ps
module vid_sync_gen
  import vsg_pkg::*;
#(
  parameter int LINE_PIX     = 864,
  parameter int LINES        = 625,
  parameter int FIELD1_LINES = 313,
  parameter int HBLANK       = 144
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic       cfg_addr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic       hsync_no,
  output logic       field_vsync_o,
  output logic       pix_valid_o
);

  localparam int PIX_W  = $clog2(LINE_PIX);
  localparam int LINE_W = $clog2(LINES + 1);

  cfg_t              act;
  logic              restart;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;

  vsg_cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .act_o     (act),
    .restart_o (restart)
  );

  vsg_counters #(.LINE_PIX(LINE_PIX), .LINES(LINES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .pix_o  (pix),
    .line_o (line)
  );

  vsg_outputs #(
    .LINE_PIX(LINE_PIX), .LINES(LINES), .FIELD1_LINES(FIELD1_LINES), .HBLANK(HBLANK)
  ) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (restart),
    .cfg_i         (act),
    .pix_i         (pix),
    .line_i        (line),
    .hsync_no      (hsync_no),
    .field_vsync_o (field_vsync_o),
    .pix_valid_o   (pix_valid_o)
  );

endmodule

// File: tb/sim_vid_sync_gen.sv
`timescale 1ns/1ps
module sim_vid_sync_gen;

  localparam int LP = 300;
  localparam int LN = 11;
  localparam int F1 = 6;
  localparam int HB = 144;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic       cfg_addr_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic       hsync_no, field_vsync_o, pix_valid_o;

  always #2.5 clk_i = ~clk_i;

  vid_sync_gen #(.LINE_PIX(LP), .LINES(LN), .FIELD1_LINES(F1), .HBLANK(HB)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .hsync_no(hsync_no), .field_vsync_o(field_vsync_o),
    .pix_valid_o(pix_valid_o)
  );

  typedef enum int {K_HSW, K_HPER, K_DEOFF, K_DEW, K_FRISE_OFF, K_FFALL_OFF,
                    K_FLOW_W, K_FRISE_LN, K_FFALL_LN} kind_t;
  typedef struct { kind_t k; int v; string tag; } item_t;

  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0, hs_fall = 0, de_rise = 0, fv_fall = 0;
  int hs_cnt = 0, cnt_at_rise = 0, cnt_at_fall = 0;
  logic hs_p = 1'b1, fv_p = 1'b1, de_p = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ev(input kind_t k, input int v);
    if (sb.size() > 0 && sb[0].k == k) begin
      check(v == sb[0].v, sb[0].tag, v, sb[0].v);
      void'(sb.pop_front());
    end
  endtask

  // monitor: measures edges and retires scoreboard items
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (hs_p && !hsync_no) begin hs_cnt++; ev(K_HPER, cyc - hs_fall); hs_fall = cyc; end
      if (!hs_p && hsync_no) ev(K_HSW, cyc - hs_fall);
      if (!de_p && pix_valid_o) begin ev(K_DEOFF, cyc - hs_fall); de_rise = cyc; end
      if (de_p && !pix_valid_o) ev(K_DEW, cyc - de_rise);
      if (fv_p && !field_vsync_o) begin
        ev(K_FFALL_OFF, cyc - hs_fall);
        ev(K_FFALL_LN, hs_cnt - cnt_at_rise);
        fv_fall = cyc; cnt_at_fall = hs_cnt;
      end
      if (!fv_p && field_vsync_o) begin
        ev(K_FRISE_OFF, cyc - hs_fall);
        ev(K_FLOW_W, cyc - fv_fall);
        ev(K_FRISE_LN, hs_cnt - cnt_at_fall);
        cnt_at_rise = hs_cnt;
      end
    end
    hs_p = hsync_no; fv_p = field_vsync_o; de_p = pix_valid_o;
  end

  // driver side of the scoreboard
  task automatic expect_ev(input kind_t k, input int v, input string tag);
    int n = 0;
    sb.push_back('{k, v, tag});
    while (sb.size() > 0 && n < 4000) begin @(negedge clk_i); n++; end
    if (sb.size() > 0) begin
      check(1'b0, {tag, " (no event)"}, -1, v);
      sb.delete();
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic restart(input logic [3:0] ctl);
    wr(1'b0, {4'd0, ctl | 4'h8});
    wr(1'b0, {4'd0, ctl & 4'h7});
  endtask

  task automatic wait_lines(input int n);
    repeat (n * LP) @(negedge clk_i);
  endtask

  function automatic int hs_len(input int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 16 : 128;
  endfunction

  function automatic int dly(input int c);
    return (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction

  function automatic logic [7:0] tim(input int adj, input int vsw, input int d, input int hsw);
    return {2'(adj), 2'(vsw), 2'(d), 2'(hsw)};
  endfunction

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int act_cnt;
    repeat (3) @(negedge clk_i);
    check(hsync_no && field_vsync_o && !pix_valid_o, "R1 reset outputs",
          {hsync_no, field_vsync_o, pix_valid_o}, 3'b110);
    rst_ni = 1'b1;

    // R1: slave after reset stays quiet
    act_cnt = 0;
    repeat (700) begin
      @(negedge clk_i);
      if (!hsync_no || !field_vsync_o || pix_valid_o) act_cnt++;
    end
    check(act_cnt == 0, "R1 slave after reset", act_cnt, 0);

    // R2 R3 R4 R6 over every code
    for (int c = 0; c < 4; c++) begin
      wr(1'b1, tim(c, 0, c, c));
      restart(4'h1);
      wait_lines(2);
      expect_ev(K_HSW, hs_len(c), "R3 hsync width");
      expect_ev(K_HPER, LP, "R2 line period");
      expect_ev(K_DEOFF, HB + c, "R4 pixel start");
      expect_ev(K_DEW, LP - HB - c, "R4 pixel window");
      expect_ev(K_FRISE_OFF, dly(c), "R6 field rise offset");
      expect_ev(K_FFALL_OFF, dly(c), "R6 field fall offset");
    end

    // R5: field lengths alternate
    expect_ev(K_FRISE_LN, F1, "R5 first field lines");
    expect_ev(K_FFALL_LN, LN - F1, "R5 second field lines");
    expect_ev(K_FRISE_LN, F1, "R5 first field lines again");
    expect_ev(K_FFALL_LN, LN - F1, "R5 second field lines again");

    // R7: half-line shift
    wr(1'b1, tim(0, 0, 2, 0));
    restart(4'h5);
    wait_lines(2);
    expect_ev(K_FRISE_OFF, 8 + LP / 2, "R7 half-line rise");
    expect_ev(K_FFALL_OFF, 8 + LP / 2, "R7 half-line fall");
    expect_ev(K_FRISE_LN, F1, "R7 field lines kept");

    // R8: vertical pulse mode
    for (int c = 0; c < 4; c++) begin
      wr(1'b1, tim(0, c, 3 - c, 0));
      restart(4'h3);
      wait_lines(2);
      expect_ev(K_FFALL_OFF, dly(3 - c), "R8 vsync offset");
      expect_ev(K_FLOW_W, hs_len(c), "R8 vsync width");
    end
    expect_ev(K_FFALL_LN, LN - F1, "R8 pulse spacing field 2 to 1");
    expect_ev(K_FFALL_LN, F1, "R8 pulse spacing field 1 to 2");

    // R9: hold high keeps counting, falling edge restarts
    wr(1'b0, 8'h0B);
    wait_lines(1);
    expect_ev(K_HPER, LP, "R9 counting while held high");
    wait_lines(1);
    wr(1'b0, 8'h03);
    @(negedge clk_i);
    check(hsync_no == 1'b1, "R9 cleared cycle", hsync_no, 1);
    @(negedge clk_i);
    check(hsync_no == 1'b0, "R9 sync after restart", hsync_no, 0);
    repeat (100) @(negedge clk_i);
    wr(1'b0, 8'h03);
    expect_ev(K_HPER, LP, "R9 no restart when already low");

    // R10: writes wait for a restart
    wr(1'b1, tim(0, 0, 0, 3));
    wait_lines(1);
    expect_ev(K_HSW, 1, "R10 width unchanged before restart");
    wr(1'b0, 8'h00);
    expect_ev(K_HPER, LP, "R10 master kept before restart");
    restart(4'h1);
    wait_lines(2);
    expect_ev(K_HSW, 128, "R10 width after restart");

    // R1: slave after restart
    restart(4'h0);
    repeat (2) @(negedge clk_i);
    act_cnt = 0;
    repeat (700) begin
      @(negedge clk_i);
      if (!hsync_no || !field_vsync_o || pix_valid_o) act_cnt++;
    end
    check(act_cnt == 0, "R1 slave after restart", act_cnt, 0);

    finish_run();
  end

endmodule